// File: doc/BRIEF.md
# Keyboard Input Controller on a Memory-Mapped Bus

This block lets a processor read key codes from a keyboard-side source through two registers on a shared memory and I/O bus. The status register holds a ready flag and an interrupt-enable flag. The data register holds the most recent key code. When a key arrives, the controller stores the code and raises the ready flag. An interrupt request is asserted for as long as both flags are set.

The controller has two state machines. One serves bus reads and writes. The other accepts keys from a valid/accept handshake. Both machines advance only on an internal tick that fires once every `TICK_DIV` system clocks. Every register update therefore trails the bus and key events by whole tick periods, and software can see that delay. Reading the data register clears the ready flag on the tick after the access has been acknowledged. The processor can also write either register directly.

Top module: `kbd_ctrl`

## Requirements
- R1: After synchronous reset, `bus_ack`, `key_accept`, `irq` and `bus_rdata` are 0, and both registers read as 0.
- R2: The internal tick fires once every `TICK_DIV` clocks, and both state machines change state only on a tick. When `key_valid` is held high, successive `key_accept` pulses are therefore exactly 2*`TICK_DIV` clocks apart.
- R3: The bus machine handles a request in four phases:
  - on a tick in idle, it captures the request;
  - on the next tick it decodes the address;
  - on the tick after that it performs the access and pulses `bus_ack` high for exactly one clock, with `bus_rdata` valid during that pulse;
  - on the following tick it returns to idle.
- R4: Only address 16'hFE00 (status register) and address 16'hFE02 (data register) are decoded. A request to any other address produces no `bus_ack` and changes no register.
- R5: The status register has the ready flag in bit 15 and interrupt-enable in bit 14. Every other bit reads as 0. A write loads both flags from `bus_wdata[15]` and `bus_wdata[14]`.
- R6: The data register returns the key code in bits 7:0, and bits 15:8 read as 0. A write stores `bus_wdata[7:0]`.
- R7: On a tick, the key machine accepts a held `key_valid` and pulses `key_accept` high for one clock. On the next tick it loads the key code into the data register and sets the ready flag.
- R8: A read of the data register clears the ready flag on the tick after its `bus_ack`, not earlier. A read of the status register does not clear it.
- R9: A key that arrives while ready is already set overwrites the data register, and ready stays set.
- R10: `irq` is high exactly while the ready flag and the interrupt-enable flag are both set.
- R11: When a key load falls on the same clock as a processor write or a read-clear, the key load wins. Ready ends up set and the data register holds the new key.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_req | input | 1 | Bus request, held until `bus_ack` |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 16 | Bus address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, valid with `bus_ack` |
| bus_ack | output | 1 | One-clock completion pulse |
| key_valid | input | 1 | Key code offered, held until `key_accept` |
| key_data | input | 8 | Key code |
| key_accept | output | 1 | One-clock pulse when a key is taken |
| irq | output | 1 | Interrupt request |

## Verification
The hardest case to reach is a key load that lands on the same tick as a processor status write, or on the same tick as the read-triggered clear of ready. The bench does not know the tick phase, but it uses the fact that any `TICK_DIV` consecutive clocks contain exactly one tick. It raises the bus request, waits one or two full tick periods, and only then offers the key. This places the key's load tick exactly on the access tick, or on the clear tick. A behavioural model, stepped on every clock, checks acknowledge, read data, accept and interrupt throughout.

// File: rtl/kbd_pkg.sv
package kbd_pkg;
  typedef enum logic [1:0] {B_IDLE, B_DECODE, B_ACCESS, B_ACK} bus_st_e;
  typedef enum logic {K_WAIT, K_LOAD} key_st_e;
  typedef enum logic [1:0] {SEL_NONE, SEL_STAT, SEL_DATA} reg_sel_e;
endpackage

// File: rtl/kbd_tick_gen.sv
module kbd_tick_gen #(
  parameter int TICK_DIV = 4
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);
  localparam int CW = (TICK_DIV > 2) ? $clog2(TICK_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(TICK_DIV - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) cnt <= '0;
    else if (cnt == LAST) cnt <= '0;
    else cnt <= cnt + 1'b1;
  end

  assign tick = (cnt == LAST);

  // R2: a tick is never followed by another tick on the next clock
  assert_tick_spacing_R2: assert property (@(posedge clk) disable iff (rst)
    tick |=> !tick);
endmodule

// File: rtl/kbd_bus_fsm.sv
module kbd_bus_fsm
  import kbd_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16,
  parameter logic [ADDR_W-1:0] STAT_ADDR = 16'hFE00,
  parameter logic [ADDR_W-1:0] DATA_ADDR = 16'hFE02
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              bus_req,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic [DATA_W-1:0] stat_val,
  input  logic [DATA_W-1:0] data_val,
  output logic              bus_ack,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              wr_stat,
  output logic              wr_data,
  output logic [DATA_W-1:0] wdata_q,
  output logic              clr_ready
);
  bus_st_e           st;
  reg_sel_e          sel_q;
  reg_sel_e          sel_d;
  logic [ADDR_W-1:0] addr_q;
  logic              we_q;

  always_comb begin
    if (addr_q == STAT_ADDR) sel_d = SEL_STAT;
    else if (addr_q == DATA_ADDR) sel_d = SEL_DATA;
    else sel_d = SEL_NONE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= B_IDLE;
      sel_q     <= SEL_NONE;
      addr_q    <= '0;
      we_q      <= 1'b0;
      wdata_q   <= '0;
      bus_ack   <= 1'b0;
      bus_rdata <= '0;
    end else begin
      bus_ack <= 1'b0;
      if (tick) begin
        unique case (st)
          B_IDLE: begin
            if (bus_req) begin
              addr_q  <= bus_addr;
              we_q    <= bus_we;
              wdata_q <= bus_wdata;
              st      <= B_DECODE;
            end
          end
          B_DECODE: begin
            sel_q <= sel_d;
            st    <= (sel_d == SEL_NONE) ? B_IDLE : B_ACCESS;
          end
          B_ACCESS: begin
            if (!we_q) bus_rdata <= (sel_q == SEL_STAT) ? stat_val : data_val;
            bus_ack <= 1'b1;
            st      <= B_ACK;
          end
          B_ACK: st <= B_IDLE;
          default: st <= B_IDLE;
        endcase
      end
    end
  end

  assign wr_stat   = tick && (st == B_ACCESS) && we_q && (sel_q == SEL_STAT);
  assign wr_data   = tick && (st == B_ACCESS) && we_q && (sel_q == SEL_DATA);
  assign clr_ready = tick && (st == B_ACK) && !we_q && (sel_q == SEL_DATA);

  // R3: acknowledge lasts one clock
  assert_ack_pulse_R3: assert property (@(posedge clk) disable iff (rst)
    bus_ack |=> !bus_ack);
  // R2: bus state only moves on a tick
  assert_bus_hold_R2: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(st));
  // R3: an acknowledge is always followed by the wait-for-tick phase
  assert_ack_phase_R3: assert property (@(posedge clk) disable iff (rst)
    bus_ack |-> (st == B_ACK));
  // R4: at most one register action per clock
  assert_one_action_R4: assert property (@(posedge clk) disable iff (rst)
    $onehot0({wr_stat, wr_data, clr_ready}));
endmodule

// File: rtl/kbd_key_fsm.sv
module kbd_key_fsm
  import kbd_pkg::*;
#(
  parameter int KEY_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             key_valid,
  input  logic [KEY_W-1:0] key_data,
  output logic             key_accept,
  output logic             load,
  output logic [KEY_W-1:0] load_data
);
  key_st_e st;

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= K_WAIT;
      key_accept <= 1'b0;
      load_data  <= '0;
    end else begin
      key_accept <= 1'b0;
      if (tick) begin
        unique case (st)
          K_WAIT: begin
            if (key_valid) begin
              load_data  <= key_data;
              key_accept <= 1'b1;
              st         <= K_LOAD;
            end
          end
          K_LOAD: st <= K_WAIT;
          default: st <= K_WAIT;
        endcase
      end
    end
  end

  assign load = tick && (st == K_LOAD);

  // R7: accept is a single-clock pulse
  assert_accept_pulse_R7: assert property (@(posedge clk) disable iff (rst)
    key_accept |=> !key_accept);
  // R7: a key is only taken while offered
  assert_accept_valid_R7: assert property (@(posedge clk) disable iff (rst)
    key_accept |-> $past(key_valid));
  // R2: key state only moves on a tick
  assert_key_hold_R2: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(st));
endmodule

// File: rtl/kbd_regs.sv
module kbd_regs #(
  parameter int DATA_W = 16,
  parameter int KEY_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_stat,
  input  logic              wr_data,
  input  logic [DATA_W-1:0] wdata,
  input  logic              clr_ready,
  input  logic              load,
  input  logic [KEY_W-1:0]  load_data,
  output logic [DATA_W-1:0] stat_val,
  output logic [DATA_W-1:0] data_val,
  output logic              irq
);
  localparam int RDY_BIT = DATA_W - 1;
  localparam int IE_BIT  = DATA_W - 2;

  logic             ready;
  logic             ie;
  logic [KEY_W-1:0] code;
  logic             unused_wbits;

  assign unused_wbits = ^wdata[IE_BIT-1:KEY_W];

  always_ff @(posedge clk) begin
    if (rst) begin
      ready <= 1'b0;
      ie    <= 1'b0;
      code  <= '0;
    end else begin
      if (wr_stat) ie <= wdata[IE_BIT];
      if (load) begin
        ready <= 1'b1;
        code  <= load_data;
      end else begin
        if (wr_stat) ready <= wdata[RDY_BIT];
        else if (clr_ready) ready <= 1'b0;
        if (wr_data) code <= wdata[KEY_W-1:0];
      end
    end
  end

  assign stat_val = {ready, ie, {(DATA_W-2){1'b0}}};
  assign data_val = {{(DATA_W-KEY_W){1'b0}}, code};
  assign irq      = ready & ie;

  // R7 / R11: a key load always leaves ready set
  assert_load_ready_R11: assert property (@(posedge clk) disable iff (rst)
    load |=> ready);
  // R9: loaded code matches the captured key
  assert_load_code_R9: assert property (@(posedge clk) disable iff (rst)
    load |=> (code == $past(load_data)));
  // R8: a read-clear without a competing load drops ready
  assert_clear_R8: assert property (@(posedge clk) disable iff (rst)
    (clr_ready && !load) |=> !ready);
endmodule

// File: rtl/kbd_ctrl.sv
module kbd_ctrl #(
  parameter int ADDR_W   = 16,
  parameter int DATA_W   = 16,
  parameter int KEY_W    = 8,
  parameter int TICK_DIV = 4,
  parameter logic [ADDR_W-1:0] STAT_ADDR = 16'hFE00,
  parameter logic [ADDR_W-1:0] DATA_ADDR = 16'hFE02
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_req,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              bus_ack,
  input  logic              key_valid,
  input  logic [KEY_W-1:0]  key_data,
  output logic              key_accept,
  output logic              irq
);
  logic              tick;
  logic              wr_stat;
  logic              wr_data;
  logic              clr_ready;
  logic              load;
  logic [KEY_W-1:0]  load_data;
  logic [DATA_W-1:0] wdata_q;
  logic [DATA_W-1:0] stat_val;
  logic [DATA_W-1:0] data_val;

  kbd_tick_gen #(.TICK_DIV(TICK_DIV)) u_tick (
    .clk(clk), .rst(rst), .tick(tick)
  );

  kbd_bus_fsm #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .STAT_ADDR(STAT_ADDR), .DATA_ADDR(DATA_ADDR)
  ) u_bus (
    .clk(clk), .rst(rst), .tick(tick),
    .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .stat_val(stat_val), .data_val(data_val),
    .bus_ack(bus_ack), .bus_rdata(bus_rdata),
    .wr_stat(wr_stat), .wr_data(wr_data), .wdata_q(wdata_q),
    .clr_ready(clr_ready)
  );

  kbd_key_fsm #(.KEY_W(KEY_W)) u_key (
    .clk(clk), .rst(rst), .tick(tick),
    .key_valid(key_valid), .key_data(key_data),
    .key_accept(key_accept), .load(load), .load_data(load_data)
  );

  kbd_regs #(.DATA_W(DATA_W), .KEY_W(KEY_W)) u_regs (
    .clk(clk), .rst(rst),
    .wr_stat(wr_stat), .wr_data(wr_data), .wdata(wdata_q),
    .clr_ready(clr_ready), .load(load), .load_data(load_data),
    .stat_val(stat_val), .data_val(data_val), .irq(irq)
  );

  // R10: interrupt falls only when ready or enable went away
  assert_irq_source_R10: assert property (@(posedge clk) disable iff (rst)
    $fell(irq) |-> (!stat_val[DATA_W-1] || !stat_val[DATA_W-2]));
endmodule

// File: tb/tb_kbd_ctrl.sv
module tb_kbd_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int DIV        = 4;
  localparam logic [15:0] A_STAT = 16'hFE00;
  localparam logic [15:0] A_DATA = 16'hFE02;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_req = 1'b0;
  logic        bus_we = 1'b0;
  logic [15:0] bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        bus_ack;
  logic        key_valid = 1'b0;
  logic [7:0]  key_data = '0;
  logic        key_accept;
  logic        irq;

  int n_cmp = 0;
  int n_bad = 0;
  int cyc = 0;
  bit done = 1'b0;

  kbd_ctrl #(.TICK_DIV(DIV)) dut (
    .clk(clk), .rst(rst), .bus_req(bus_req), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_ack(bus_ack), .key_valid(key_valid), .key_data(key_data),
    .key_accept(key_accept), .irq(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int m_cnt = 0, m_bph = 0, m_kph = 0, m_sel = 0;
  int m_ready = 0, m_ie = 0, m_data = 0, m_rdata = 0;
  int m_ack = 0, m_kacc = 0, m_kd = 0, m_we = 0, m_wd = 0, m_addr = 0;

  always @(posedge clk) begin
    if (rst) begin
      m_cnt = 0; m_bph = 0; m_kph = 0; m_sel = 0;
      m_ready = 0; m_ie = 0; m_data = 0; m_rdata = 0;
      m_ack = 0; m_kacc = 0; m_kd = 0; m_we = 0; m_wd = 0; m_addr = 0;
    end else begin
      bit t, ws, wd, clr, ld;
      t = (m_cnt == DIV - 1);
      m_cnt = t ? 0 : m_cnt + 1;
      m_ack = 0; m_kacc = 0; ws = 0; wd = 0; clr = 0; ld = 0;
      if (t) begin
        case (m_bph)
          0: if (bus_req) begin
               m_addr = int'(bus_addr); m_we = int'(bus_we); m_wd = int'(bus_wdata); m_bph = 1;
             end
          1: begin
               m_sel = (m_addr == int'(A_STAT)) ? 1 : (m_addr == int'(A_DATA)) ? 2 : 0;
               m_bph = (m_sel == 0) ? 0 : 2;
             end
          2: begin
               if (m_we == 0) m_rdata = (m_sel == 1) ? (m_ready * 32768 + m_ie * 16384) : m_data;
               else if (m_sel == 1) ws = 1;
               else wd = 1;
               m_ack = 1; m_bph = 3;
             end
          default: begin
               if (m_we == 0 && m_sel == 2) clr = 1;
               m_bph = 0;
             end
        endcase
        if (m_kph == 0) begin
          if (key_valid) begin m_kd = int'(key_data); m_kacc = 1; m_kph = 1; end
        end else begin
          ld = 1; m_kph = 0;
        end
      end
      if (ws) begin m_ready = (m_wd >> 15) & 1; m_ie = (m_wd >> 14) & 1; end
      if (wd) m_data = m_wd & 255;
      if (clr) m_ready = 0;
      if (ld) begin m_data = m_kd; m_ready = 1; end
    end
  end

  always @(negedge clk) begin
    if (!rst && !done) begin
      chk("R3 model ack", 32'(bus_ack), 32'(m_ack));
      chk("R5 model rdata", 32'(bus_rdata), 32'(m_rdata));
      chk("R7 model accept", 32'(key_accept), 32'(m_kacc));
      chk("R10 model irq", 32'(irq), 32'(m_ready & m_ie));
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !done) begin
      done = 1'b1;
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=<%0d", cyc, 100000);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  // ---------------- stimulus tasks ----------------
  task automatic bus_xfer(input logic we, input logic [15:0] a, input logic [15:0] wd,
                          output logic [15:0] rd);
    int n;
    bus_we = we; bus_addr = a; bus_wdata = wd; bus_req = 1'b1;
    rd = '0;
    for (n = 0; n < 20 * DIV; n++) begin
      @(negedge clk);
      if (bus_ack) begin rd = bus_rdata; break; end
    end
    bus_req = 1'b0;
  endtask

  task automatic key_send(input logic [7:0] d);
    int n;
    key_data = d; key_valid = 1'b1;
    for (n = 0; n < 20 * DIV; n++) begin
      @(negedge clk);
      if (key_accept) break;
    end
    key_valid = 1'b0;
    repeat (DIV + 1) @(negedge clk);
  endtask

  task automatic collide(input logic we, input logic [15:0] a, input logic [15:0] wd,
                         input int delay_ticks, input logic [7:0] k, output logic [15:0] rd);
    bit got_ack, got_acc;
    int n;
    got_ack = 0; got_acc = 0; rd = '0;
    bus_we = we; bus_addr = a; bus_wdata = wd; bus_req = 1'b1;
    repeat (delay_ticks * DIV) @(negedge clk);
    key_data = k; key_valid = 1'b1;
    for (n = 0; n < 20 * DIV; n++) begin
      @(negedge clk);
      if (key_accept) begin key_valid = 1'b0; got_acc = 1; end
      if (bus_ack) begin rd = bus_rdata; bus_req = 1'b0; got_ack = 1; end
      if (got_ack && got_acc) break;
    end
    bus_req = 1'b0; key_valid = 1'b0;
    repeat (2 * DIV + 1) @(negedge clk);
  endtask

  initial begin
    logic [15:0] rd;
    int t0, t1, acks;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 ack", 32'(bus_ack), 0);
    chk("R1 accept", 32'(key_accept), 0);
    chk("R1 irq", 32'(irq), 0);
    chk("R1 rdata", 32'(bus_rdata), 0);
    bus_xfer(1'b0, A_STAT, 16'h0, rd); chk("R1 status", 32'(rd), 0);
    bus_xfer(1'b0, A_DATA, 16'h0, rd); chk("R1 data", 32'(rd), 0);
    repeat (2 * DIV) @(negedge clk);

    // R2 / R9: held key gives accepts 2*DIV apart, second overwrites first
    key_data = 8'h11; key_valid = 1'b1;
    t0 = 0; t1 = 0;
    for (int n = 0; n < 20 * DIV; n++) begin
      @(negedge clk);
      if (key_accept) begin t0 = cyc; key_data = 8'h22; break; end
    end
    for (int n = 0; n < 20 * DIV; n++) begin
      @(negedge clk);
      if (key_accept) begin t1 = cyc; break; end
    end
    key_valid = 1'b0;
    chk("R2 accept spacing", 32'(t1 - t0), 32'(2 * DIV));
    repeat (DIV + 1) @(negedge clk);
    chk("R10 irq with ie clear", 32'(irq), 0);
    bus_xfer(1'b0, A_STAT, 16'h0, rd); chk("R9 ready kept", 32'(rd), 32'h8000);
    bus_xfer(1'b0, A_DATA, 16'h0, rd); chk("R9 overwrite code", 32'(rd), 32'h0022);
    repeat (DIV + 1) @(negedge clk);

    // R6 data write and readback
    bus_xfer(1'b1, A_DATA, 16'h1234, rd);
    bus_xfer(1'b0, A_DATA, 16'h0, rd); chk("R6 data write", 32'(rd), 32'h0034);
    // R5 status write
    bus_xfer(1'b1, A_STAT, 16'hFFFF, rd);
    repeat (DIV + 1) @(negedge clk);
    chk("R10 irq both set", 32'(irq), 1);
    bus_xfer(1'b0, A_STAT, 16'h0, rd); chk("R5 status bits", 32'(rd), 32'hC000);
    bus_xfer(1'b1, A_STAT, 16'h4000, rd);
    bus_xfer(1'b0, A_STAT, 16'h0, rd); chk("R5 cpu clears ready", 32'(rd), 32'h4000);
    repeat (DIV + 1) @(negedge clk);

    // R4 unmapped addresses
    acks = 0;
    bus_we = 1'b1; bus_addr = 16'hFE04; bus_wdata = 16'hFFFF; bus_req = 1'b1;
    repeat (6 * DIV) begin @(negedge clk); if (bus_ack) acks++; end
    bus_req = 1'b0;
    bus_we = 1'b0; bus_addr = 16'hFE01; bus_req = 1'b1;
    repeat (6 * DIV) begin @(negedge clk); if (bus_ack) acks++; end
    bus_req = 1'b0;
    repeat (3 * DIV) @(negedge clk);
    chk("R4 no ack on miss", 32'(acks), 0);
    bus_xfer(1'b0, A_STAT, 16'h0, rd); chk("R4 status untouched", 32'(rd), 32'h4000);
    bus_xfer(1'b0, A_DATA, 16'h0, rd); chk("R4 data untouched", 32'(rd), 32'h0034);
    repeat (DIV + 1) @(negedge clk);

    // R7 / R8 key delivery and read-clear latency
    key_send(8'h41);
    chk("R7 ready after key", 32'(irq), 1);
    bus_xfer(1'b0, A_STAT, 16'h0, rd); chk("R7 status after key", 32'(rd), 32'hC000);
    repeat (DIV + 1) @(negedge clk);
    chk("R8 status read keeps ready", 32'(irq), 1);
    bus_xfer(1'b0, A_DATA, 16'h0, rd); chk("R7 key code", 32'(rd), 32'h0041);
    chk("R8 ready still set at ack", 32'(irq), 1);
    repeat (DIV) @(negedge clk);
    chk("R8 ready cleared after tick", 32'(irq), 0);
    repeat (DIV + 1) @(negedge clk);

    // R11 key load on the same tick as a status write of ready=0
    collide(1'b1, A_STAT, 16'h4000, 1, 8'h5A, rd);
    chk("R11 load beats status write", 32'(irq), 1);
    bus_xfer(1'b0, A_DATA, 16'h0, rd); chk("R11 code after write clash", 32'(rd), 32'h005A);
    repeat (DIV + 1) @(negedge clk);
    chk("R11 ready after read", 32'(irq), 0);
    // set ready again, then clash a load with the read-clear
    key_send(8'h77);
    collide(1'b0, A_DATA, 16'h0, 2, 8'h3C, rd);
    chk("R11 read returns old code", 32'(rd), 32'h0077);
    chk("R11 load beats read-clear", 32'(irq), 1);
    bus_xfer(1'b0, A_DATA, 16'h0, rd); chk("R11 new code kept", 32'(rd), 32'h003C);
    repeat (2 * DIV) @(negedge clk);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule